// File: doc/BRIEF.md
# One-Hot Pointer Synchronous FIFO

This block is a single-clock first-in-first-out buffer. Each entry is a row of flip-flops. Two rotating one-hot rings pick the rows: one ring for writes and one for reads. A ring bit enables its row directly, so neither side decodes a binary address. The producer sees a single `full` flag and the consumer sees a single `empty` flag. No other status leaves the block. Depth and word width are parameters, and the number of entries equals `DEPTH`.

The pointers alone cannot tell a full FIFO from an empty one, because in both cases the two rings hold their 1 in the same position. A small state machine settles this by recording the direction of the last pointer movement. It has two states. `MOVE_READ` is the reset state. The transition to `MOVE_WRITE` is taken on a write-only movement, and the transition back to `MOVE_READ` on a read-only movement. The block has two instances of this machine:
- One on the write side, paired with the write ring, produces `full`.
- One on the read side, paired with a delayed copy of the write ring (the visible ring), produces `empty`.

Accepted writes pass through a pipe of `FWD_LAT` stages before the read side sees them. A word written into an empty FIFO therefore becomes readable a fixed three clock periods after its write edge. A read frees its row at once. Reads are show-ahead: `rd_data` is the head word whenever `empty` is low.

Top module: `ohp_fifo`

## Requirements
- R1: While reset is asserted and immediately after its release, `empty` is 1 and `full` is 0.
- R2: Words leave through `rd_data` in the order in which they were accepted.
- R3: A write accepted at clock edge k into an empty FIFO drives `empty` low and shows its word on `rd_data` after edge k+3. `empty` stays high before that edge.
- R4: Starting empty with no reads, `full` rises right after the `DEPTH`-th accepted write. The FIFO holds exactly `DEPTH` words.
- R5: A write while `full` is 1 and no read is accepted is ignored. The stored words and their order are unchanged, and `full` stays 1.
- R6: A read while `empty` is 1 is ignored. It changes neither the read pointer nor the words delivered later.
- R7: A read and a write in the same cycle on a full FIFO are both accepted. `full` stays 1, and the new word follows the existing words.
- R8: A read accepted on a full FIFO with no write clears `full` after that same edge.
- R9: Both pointers stay one-hot and wrap around the ring. Ordering holds over many more than `DEPTH` transfers under any mix of reads and writes.
- R10: While `empty` is 0, `rd_data` equals the oldest stored word without any read being issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | No free row for a write |
| rd_en | input | 1 | Read request, pops the head word |
| rd_data | output | WIDTH | Head word, valid while empty is 0 |
| empty | output | 1 | No word visible to the reader |

## Verification
The assertions check several rules on every cycle:
- Both rings stay one-hot.
- The write ring does not move when the FIFO is full and no read is accepted.
- The read ring does not move while `empty` is high.
- Every accepted write makes `empty` low four sampled cycles later.
- `empty` never falls unless a write was accepted exactly that many cycles earlier.

Other behaviours only the bench scenarios can show. These are the data ordering through wrap-around, the content left intact after an ignored write, the exact cycle at which `full` rises and falls, and the value presented on `rd_data`. The bench shows them by comparing every cycle against a queue model that keeps its own visibility delay.

// File: rtl/ohp_fifo_pkg.sv
package ohp_fifo_pkg;

    // Direction of the most recent pointer movement; breaks the tie when
    // the two rings are equal.
    typedef enum logic {
        MOVE_READ  = 1'b0,
        MOVE_WRITE = 1'b1
    } last_move_e;

endpackage

// File: rtl/ohp_ring.sv
module ohp_ring #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [N-1:0] ptr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= N'(1);
        end else if (adv) begin
            ptr <= {ptr[N-2:0], ptr[N-1]};
        end
    end

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ptr)); // R9

endmodule

// File: rtl/ohp_move_tracker.sv
module ohp_move_tracker
    import ohp_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    output last_move_e last
);

    last_move_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MOVE_READ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MOVE_READ: begin
                if (push && !pop) begin
                    state_d = MOVE_WRITE;
                end
            end
            MOVE_WRITE: begin
                if (pop && !push) begin
                    state_d = MOVE_READ;
                end
            end
            default: state_d = MOVE_READ;
        endcase
    end

    assign last = state_q;

endmodule

// File: rtl/ohp_bank.sv
module ohp_bank #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             wr_go,
    input  logic [DEPTH-1:0] wr_sel,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [DEPTH-1:0] rd_sel,
    output logic [WIDTH-1:0] rd_word
);

    logic [WIDTH-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (wr_go && wr_sel[g]) begin
                rows[g] <= wr_word;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_word = rd_word | (rows[i] & {WIDTH{rd_sel[i]}});
        end
    end

endmodule

// File: rtl/ohp_fifo.sv
module ohp_fifo
    import ohp_fifo_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int WIDTH   = 8,
    parameter int FWD_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);

    localparam int PIPE_LEN = (FWD_LAT < 1) ? 1 : FWD_LAT;

    logic [DEPTH-1:0]    wr_ptr, rd_ptr, vis_ptr;
    logic [PIPE_LEN-1:0] wr_pipe;
    logic                wr_acc, rd_acc, vis_push;
    last_move_e          wr_last, vis_last;

    assign rd_acc   = rd_en && !empty;
    assign wr_acc   = wr_en && (!full || rd_acc);
    assign vis_push = wr_pipe[PIPE_LEN-1];

    if (PIPE_LEN == 1) begin : g_pipe1
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wr_pipe <= '0;
            else        wr_pipe <= wr_acc;
        end
    end else begin : g_pipen
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wr_pipe <= '0;
            else        wr_pipe <= {wr_pipe[PIPE_LEN-2:0], wr_acc};
        end
    end

    ohp_ring #(.N(DEPTH)) u_wr_ring (
        .clk(clk), .rst_n(rst_n), .adv(wr_acc), .ptr(wr_ptr));

    ohp_ring #(.N(DEPTH)) u_rd_ring (
        .clk(clk), .rst_n(rst_n), .adv(rd_acc), .ptr(rd_ptr));

    ohp_ring #(.N(DEPTH)) u_vis_ring (
        .clk(clk), .rst_n(rst_n), .adv(vis_push), .ptr(vis_ptr));

    ohp_move_tracker u_wr_track (
        .clk(clk), .rst_n(rst_n), .push(wr_acc), .pop(rd_acc), .last(wr_last));

    ohp_move_tracker u_vis_track (
        .clk(clk), .rst_n(rst_n), .push(vis_push), .pop(rd_acc), .last(vis_last));

    ohp_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk(clk), .wr_go(wr_acc), .wr_sel(wr_ptr), .wr_word(wr_data),
        .rd_sel(rd_ptr), .rd_word(rd_data));

    always_comb begin
        full  = (wr_ptr == rd_ptr) && (wr_last == MOVE_WRITE);
        empty = (vis_ptr == rd_ptr) && (vis_last == MOVE_READ);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(rd_en && !empty)) |=> $stable(wr_ptr)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> $stable(rd_ptr)); // R6
    AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!full || (rd_en && !empty))) |-> ##4 !empty); // R3
    AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty) |-> $past(wr_en && (!full || (rd_en && !empty)), 4)); // R3

endmodule

// File: tb/ohp_fifo_tb_top.sv
module ohp_fifo_tb_top;

    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             full, empty;
    logic [WIDTH-1:0] rd_data;

    int tests = 0;
    int fails = 0;

    logic [WIDTH-1:0] mq[$];
    int               vis = 0;
    logic [2:0]       mpipe = '0;
    logic [WIDTH-1:0] seed = 8'h10;

    always #5 clk = ~clk;

    ohp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FWD_LAT(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

    task automatic check(input string req, input string what,
                         input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: inputs driven at the falling edge, outputs compared 1 ns later,
    // model updated at the rising edge.
    task automatic cyc(input string req, input logic w, input logic r);
        logic exp_e, exp_f, wa, ra;
        wr_en   = w;
        rd_en   = r;
        wr_data = seed;
        #1;
        exp_e = (vis == 0);
        exp_f = (mq.size() == DEPTH);
        check(req, "empty", {7'b0, empty}, {7'b0, exp_e});
        check(req, "full",  {7'b0, full},  {7'b0, exp_f});
        if (!exp_e) check(req, "rd_data", rd_data, mq[0]);
        ra = r && !exp_e;
        wa = w && (!exp_f || ra);
        @(posedge clk);
        if (ra) void'(mq.pop_front());
        if (wa) begin
            mq.push_back(seed);
            seed = seed * 8'd5 + 8'd3;
        end
        vis   = vis + int'(mpipe[2]) - int'(ra);
        mpipe = {mpipe[1:0], wa};
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "empty in reset", {7'b0, empty}, 8'd1);
        check("R1", "full in reset",  {7'b0, full},  8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc("R1", 1'b0, 1'b0);

        // R3: single write into empty, watch the three-period delay
        cyc("R3", 1'b1, 1'b0);
        cyc("R3", 1'b0, 1'b0);
        cyc("R3", 1'b0, 1'b0);
        cyc("R3", 1'b0, 1'b0);
        cyc("R10", 1'b0, 1'b0);
        cyc("R2", 1'b0, 1'b1);
        cyc("R3", 1'b0, 1'b0);
        cyc("R3", 1'b0, 1'b0);
        cyc("R3", 1'b0, 1'b0);

        // R6: reads on empty ignored
        cyc("R6", 1'b0, 1'b1);
        cyc("R6", 1'b0, 1'b1);

        // R4: fill to capacity
        for (int i = 0; i < DEPTH; i++) cyc("R4", 1'b1, 1'b0);
        cyc("R4", 1'b0, 1'b0);
        cyc("R4", 1'b0, 1'b0);
        cyc("R4", 1'b0, 1'b0);
        // R5: writes while full ignored
        cyc("R5", 1'b1, 1'b0);
        cyc("R5", 1'b1, 1'b0);
        // R7: simultaneous on full
        cyc("R7", 1'b1, 1'b1);
        cyc("R7", 1'b1, 1'b1);
        // R8: read from full clears full next cycle
        cyc("R8", 1'b0, 1'b1);
        cyc("R8", 1'b0, 1'b0);
        // drain: R2 order
        for (int i = 0; i < DEPTH + 4; i++) cyc("R2", 1'b0, 1'b1);

        // R9: sweep every read/write pattern across many wraps
        for (int p = 0; p < 64; p++) begin
            for (int s = 0; s < 12; s++) begin
                cyc("R9", p[s % 6], p[(s + 3) % 6] | s[0]);
            end
        end
        for (int i = 0; i < DEPTH + 4; i++) cyc("R2", 1'b0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule